// File: doc/BRIEF.md
# Guarded Flash-Mode Entry Sequencer

This block sits behind an SPI slave front end and decides whether the device switches into a special flash-access mode, and into which variant of it. Register writes arrive as a stream of single-beat transactions. Each beat carries a source flag (SPI or processor), a register select (mode-select or key) and an 8-bit data byte. Only SPI-sourced beats have any effect. The mode is entered by an ordered pair of writes: first a mode code, then the key. Entry also requires a set of enable inputs to be in their permitted state.

On entry the block raises a sticky mode-active latch. That latch halts the processor and disables the compute engine. On the cycle of entry the block also sends a one-cycle reset pulse to the flash controller and, for the erase variant, a one-cycle erase request. A secure flag limits entry to the erase variant. Completion of any mass erase clears the secure flag. Only a system reset leaves the mode. The write stream interface never applies back-pressure: `wr_ready` is held high, and every beat with `wr_valid` high is consumed on that clock edge.

Top module: `fm_entry_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all outputs except `wr_ready` are 0, and `mode_code` reads 0x00.
- R2: An accepted SPI beat with `wr_sel`=0 stores `wr_data` into the mode-select register. The new value appears on `mode_code` one cycle after the accepting edge.
- R3: Beats with `wr_src_spi`=0 are ignored. `mode_code` and every mode output stay unchanged, whatever the values of `wr_sel` and `wr_data`.
- R4: Every accepted SPI beat with `wr_sel`=1 clears `mode_code` to 0x00 one cycle after the accepting edge, whatever the key value.
- R5: A key beat of 0x96 enters the mode (`mode_active`, `cpu_halt` and `ce_disable` high one cycle after the accepting edge) only if all of the following hold at that edge: the stored code is 0xD1 or 0x2E, `dbg_en`=1, `preboot`=0, `supply_ok`=1 and `unlock_code`=4'b0010.
- R6: A key beat with any other value, a stored code that is neither 0xD1 nor 0x2E, or any unmet enable input leaves the mode inactive.
- R7: While `secure`=1, a stored code of 0x2E cannot cause entry, but 0xD1 still can.
- R8: `mode_erase` is 1 when the mode was entered with code 0xD1 and 0 when it was entered with 0x2E. It holds its value while the mode is active.
- R9: `flash_rst` is high for exactly the one cycle after the entering edge.
- R10: `erase_start` is high for exactly one cycle, together with `flash_rst`, and only on entry with code 0xD1.
- R11: `secure_set` sets `secure` on the next cycle. `erase_done` clears it on the next cycle and takes priority when both are high.
- R12: Once active, the mode stays active, with `mode_erase` unchanged and no further pulses, until `rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always 1; no back-pressure |
| wr_src_spi | input | 1 | 1 = beat came from SPI, 0 = from processor |
| wr_sel | input | 1 | 0 = mode-select register, 1 = key register |
| wr_data | input | 8 | Written byte |
| dbg_en | input | 1 | Debug enable, must be 1 for entry |
| preboot | input | 1 | Preboot flag, must be 0 for entry |
| supply_ok | input | 1 | Supply above threshold |
| unlock_code | input | 4 | Flash unlock field, must be 4'b0010 |
| secure_set | input | 1 | Sets the secure flag |
| erase_done | input | 1 | A mass erase finished; clears secure |
| mode_code | output | 8 | Current mode-select register content |
| mode_active | output | 1 | Sticky mode latch |
| mode_erase | output | 1 | Active variant: 1 erase, 0 read-back |
| cpu_halt | output | 1 | Processor halt |
| ce_disable | output | 1 | Compute engine disable |
| flash_rst | output | 1 | One-cycle flash controller reset |
| erase_start | output | 1 | One-cycle mass erase request |
| secure | output | 1 | Secure flag |

## Verification
Every result of this block is due one cycle after the edge that accepts the stimulus: the register contents, the latch, the two pulses and the secure flag. None of them has a longer path. The bench drives each beat half a period before an edge. It advances a behavioural model by that same single edge and compares all outputs at the following falling edge, on every clock. This also shows that the pulses last exactly one cycle and that the outputs stay quiet through ignored beats.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic {
    SUB_READBACK = 1'b0,
    SUB_ERASE    = 1'b1
  } fm_sub_e;

  typedef struct packed {
    logic mode_wr;
    logic key_wr;
  } fm_wr_kind_t;
endpackage

// File: rtl/fm_mode_reg.sv
module fm_mode_reg
  import fm_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [DATA_W-1:0] ERASE_CODE = 8'hD1,
  parameter logic [DATA_W-1:0] RB_CODE    = 8'h2E,
  parameter logic [DATA_W-1:0] KEY_CODE   = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  input  logic              beat_spi,
  input  logic              beat_sel,
  input  logic [DATA_W-1:0] beat_data,
  output fm_wr_kind_t       kind,
  output logic              key_match,
  output logic              code_erase,
  output logic              code_rb,
  output logic [DATA_W-1:0] code_q
);
  // Processor-side beats never reach either register.
  always_comb begin
    kind.mode_wr = beat_valid && beat_spi && !beat_sel;
    kind.key_wr  = beat_valid && beat_spi &&  beat_sel;
  end

  assign key_match  = (beat_data == KEY_CODE);
  assign code_erase = (code_q == ERASE_CODE);
  assign code_rb    = (code_q == RB_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            code_q <= '0;
    else if (kind.mode_wr) code_q <= beat_data;
    else if (kind.key_wr)  code_q <= '0;
  end
endmodule

// File: rtl/fm_gate.sv
module fm_gate #(
  parameter int                UNLOCK_W   = 4,
  parameter logic [UNLOCK_W-1:0] UNLOCK_KEY = 4'b0010
) (
  input  logic                key_wr,
  input  logic                key_match,
  input  logic                code_erase,
  input  logic                code_rb,
  input  logic                active,
  input  logic                secure,
  input  logic                dbg_en,
  input  logic                preboot,
  input  logic                supply_ok,
  input  logic [UNLOCK_W-1:0] unlock_code,
  output logic                enter,
  output logic                enter_erase
);
  logic pre_ok, code_ok;

  always_comb begin
    pre_ok  = dbg_en && !preboot && supply_ok && (unlock_code == UNLOCK_KEY);
    // Secure state leaves only the erase variant reachable.
    code_ok = code_erase || (code_rb && !secure);
    enter   = key_wr && key_match && !active && pre_ok && code_ok;
    enter_erase = code_erase;
  end
endmodule

// File: rtl/fm_latch.sv
module fm_latch
  import fm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enter,
  input  logic    enter_erase,
  input  logic    secure_set,
  input  logic    erase_done,
  output logic    active,
  output fm_sub_e sub,
  output logic    rst_pulse,
  output logic    erase_pulse,
  output logic    secure
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      sub         <= SUB_READBACK;
      rst_pulse   <= 1'b0;
      erase_pulse <= 1'b0;
    end else begin
      rst_pulse   <= enter;
      erase_pulse <= enter && enter_erase;
      if (enter) begin
        active <= 1'b1;
        sub    <= enter_erase ? SUB_ERASE : SUB_READBACK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          secure <= 1'b0;
    else if (erase_done) secure <= 1'b0;
    else if (secure_set) secure <= 1'b1;
  end
endmodule

// File: rtl/fm_entry_seq.sv
module fm_entry_seq
  import fm_pkg::*;
#(
  parameter int                  DATA_W     = 8,
  parameter int                  UNLOCK_W   = 4,
  parameter logic [DATA_W-1:0]   ERASE_CODE = 8'hD1,
  parameter logic [DATA_W-1:0]   RB_CODE    = 8'h2E,
  parameter logic [DATA_W-1:0]   KEY_CODE   = 8'h96,
  parameter logic [UNLOCK_W-1:0] UNLOCK_KEY = 4'b0010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic                wr_src_spi,
  input  logic                wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                dbg_en,
  input  logic                preboot,
  input  logic                supply_ok,
  input  logic [UNLOCK_W-1:0] unlock_code,
  input  logic                secure_set,
  input  logic                erase_done,
  output logic [DATA_W-1:0]   mode_code,
  output logic                mode_active,
  output logic                mode_erase,
  output logic                cpu_halt,
  output logic                ce_disable,
  output logic                flash_rst,
  output logic                erase_start,
  output logic                secure
);
  fm_wr_kind_t kind;
  logic        key_match, code_erase, code_rb, enter, enter_erase;
  fm_sub_e     sub;

  assign wr_ready = 1'b1;

  fm_mode_reg #(
    .DATA_W(DATA_W), .ERASE_CODE(ERASE_CODE), .RB_CODE(RB_CODE), .KEY_CODE(KEY_CODE)
  ) u_mode_reg (
    .clk(clk), .rst_n(rst_n),
    .beat_valid(wr_valid && wr_ready), .beat_spi(wr_src_spi),
    .beat_sel(wr_sel), .beat_data(wr_data),
    .kind(kind), .key_match(key_match),
    .code_erase(code_erase), .code_rb(code_rb), .code_q(mode_code)
  );

  fm_gate #(.UNLOCK_W(UNLOCK_W), .UNLOCK_KEY(UNLOCK_KEY)) u_gate (
    .key_wr(kind.key_wr), .key_match(key_match),
    .code_erase(code_erase), .code_rb(code_rb),
    .active(mode_active), .secure(secure),
    .dbg_en(dbg_en), .preboot(preboot), .supply_ok(supply_ok),
    .unlock_code(unlock_code),
    .enter(enter), .enter_erase(enter_erase)
  );

  fm_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .enter(enter), .enter_erase(enter_erase),
    .secure_set(secure_set), .erase_done(erase_done),
    .active(mode_active), .sub(sub),
    .rst_pulse(flash_rst), .erase_pulse(erase_start), .secure(secure)
  );

  assign mode_erase = (sub == SUB_ERASE);
  assign cpu_halt   = mode_active;
  assign ce_disable = mode_active;
endmodule

// File: rtl/fm_entry_chk.sv
module fm_entry_chk #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY_CODE = 8'h96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_src_spi,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              erase_done,
  input logic [DATA_W-1:0] mode_code,
  input logic              mode_active,
  input logic              mode_erase,
  input logic              flash_rst,
  input logic              erase_start,
  input logic              secure
);
  p_cpu_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_src_spi) |=> $stable(mode_code));

  p_key_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_src_spi && wr_sel) |=> (mode_code == '0));

  p_entry_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_active) |-> $past(wr_valid && wr_src_spi && wr_sel && wr_data == KEY_CODE));

  p_secure_blocks_rb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mode_active) && !mode_erase) |-> !$past(secure));

  p_rst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rst |=> !flash_rst);

  p_erase_with_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (flash_rst && mode_erase && $rose(mode_active)));

  p_secure_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> !secure);

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_active |=> (mode_active && $stable(mode_erase) && !flash_rst));
endmodule

bind fm_entry_seq fm_entry_chk #(.DATA_W(DATA_W), .KEY_CODE(KEY_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_src_spi(wr_src_spi),
  .wr_sel(wr_sel), .wr_data(wr_data), .erase_done(erase_done),
  .mode_code(mode_code), .mode_active(mode_active), .mode_erase(mode_erase),
  .flash_rst(flash_rst), .erase_start(erase_start), .secure(secure)
);

// File: tb/test_fm_entry_seq.sv
module test_fm_entry_seq;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_src_spi = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       dbg_en = 1'b1, preboot = 1'b0, supply_ok = 1'b1;
  logic [3:0] unlock_code = 4'b0010;
  logic       secure_set = 1'b0, erase_done = 1'b0;
  logic       wr_ready;
  logic [7:0] mode_code;
  logic       mode_active, mode_erase, cpu_halt, ce_disable, flash_rst, erase_start, secure;

  int checks = 0, errors = 0;
  // reference model state
  int m_code; bit m_act, m_ers, m_sec, m_frst, m_estart;

  always #(PERIOD/2) clk = ~clk;

  fm_entry_seq i_fm_entry_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_src_spi(wr_src_spi), .wr_sel(wr_sel), .wr_data(wr_data),
    .dbg_en(dbg_en), .preboot(preboot), .supply_ok(supply_ok),
    .unlock_code(unlock_code), .secure_set(secure_set), .erase_done(erase_done),
    .mode_code(mode_code), .mode_active(mode_active), .mode_erase(mode_erase),
    .cpu_halt(cpu_halt), .ce_disable(ce_disable), .flash_rst(flash_rst),
    .erase_start(erase_start), .secure(secure)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string scen);
    chk("R2", {scen, " mode_code"}, mode_code, m_code);
    chk("R5", {scen, " mode_active"}, mode_active, m_act);
    chk("R5", {scen, " cpu_halt"}, cpu_halt, m_act);
    chk("R5", {scen, " ce_disable"}, ce_disable, m_act);
    chk("R8", {scen, " mode_erase"}, mode_erase, m_act ? m_ers : 0);
    chk("R9", {scen, " flash_rst"}, flash_rst, m_frst);
    chk("R10", {scen, " erase_start"}, erase_start, m_estart);
    chk("R11", {scen, " secure"}, secure, m_sec);
    chk("R13", {scen, " wr_ready"}, wr_ready, 1);
  endtask

  // One clock: drive at negedge, advance model by one edge, compare at next negedge.
  task automatic step(string scen, bit v, bit spi, bit sel, int d, bit sset = 0, bit edone = 0);
    bit pre_ok, go;
    wr_valid = v; wr_src_spi = spi; wr_sel = sel; wr_data = d[7:0];
    secure_set = sset; erase_done = edone;
    pre_ok = dbg_en && !preboot && supply_ok && unlock_code == 4'b0010;
    go = 0;
    if (v && spi && sel && d == 'h96 && !m_act && pre_ok &&
        (m_code == 'hD1 || (m_code == 'h2E && !m_sec))) go = 1;
    m_frst = go;
    m_estart = go && m_code == 'hD1;
    if (go) begin m_act = 1; m_ers = (m_code == 'hD1); end
    if (v && spi) m_code = sel ? 0 : d;
    if (edone) m_sec = 0; else if (sset) m_sec = 1;
    @(posedge clk); @(negedge clk);
    wr_valid = 0; secure_set = 0; erase_done = 0;
    compare_all(scen);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_valid = 0; secure_set = 0; erase_done = 0;
    dbg_en = 1; preboot = 0; supply_ok = 1; unlock_code = 4'b0010;
    m_code = 0; m_act = 0; m_ers = 0; m_sec = 0; m_frst = 0; m_estart = 0;
    #1 compare_all("R1 in reset");
    @(negedge clk); rst_n = 1;
    step("R1 after reset", 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R5 R8 R9 R10: erase entry; R12 sticky; R11 erase_done clears secure
    do_reset();
    step("R11 set", 0, 0, 0, 0, 1);
    step("R2 write D1", 1, 1, 0, 'hD1);
    step("R5 key", 1, 1, 1, 'h96);
    step("R9 pulse ends", 0, 0, 0, 0);
    step("R12 rewrite code", 1, 1, 0, 'h2E);
    step("R12 key again", 1, 1, 1, 'h96);
    step("R11 erase_done", 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step("R12 idle", 0, 0, 0, 0);

    // R8: read-back entry, no erase pulse
    do_reset();
    step("R2 write 2E", 1, 1, 0, 'h2E);
    step("R8 key", 1, 1, 1, 'h96);
    step("R10 no erase", 0, 0, 0, 0);

    // R7: secure rejects read-back, accepts erase
    do_reset();
    step("R7 secure", 0, 0, 0, 0, 1);
    step("R7 write 2E", 1, 1, 0, 'h2E);
    step("R7 key rejected", 1, 1, 1, 'h96);
    step("R7 write D1", 1, 1, 0, 'hD1);
    step("R7 key accepted", 1, 1, 1, 'h96);

    // R3 processor ignored; R4 any key clears; R6 wrong key / empty code
    do_reset();
    step("R3 cpu mode write", 1, 0, 0, 'hD1);
    step("R2 spi D1", 1, 1, 0, 'hD1);
    step("R3 cpu key", 1, 0, 1, 'h96);
    step("R4 wrong key", 1, 1, 1, 'h55);
    step("R6 key on zero code", 1, 1, 1, 'h96);
    step("R2 invalid code", 1, 1, 0, 'h12);
    step("R6 key on invalid", 1, 1, 1, 'h96);
    step("R4 idle", 0, 0, 0, 0);

    // R6: each enable input broken in turn
    for (int k = 0; k < 4; k++) begin
      do_reset();
      step("R6 code", 1, 1, 0, 'hD1);
      case (k)
        0: dbg_en = 0;
        1: preboot = 1;
        2: supply_ok = 0;
        default: unlock_code = 4'b0011;
      endcase
      step("R6 blocked key", 1, 1, 1, 'h96);
      step("R6 idle", 0, 0, 0, 0);
    end

    // R11: clear wins over set
    do_reset();
    step("R11 set", 0, 0, 0, 0, 1);
    step("R11 both", 0, 0, 0, 0, 1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule